// File: doc/BRIEF.md
# Eight-Input Vectored Interrupt Controller

This block collects up to eight interrupt requests from peripherals, ranks them by a fixed priority and raises a single interrupt line towards the CPU. The CPU answers with two low pulses on an active-low acknowledge input. The first pulse moves the winning request into service. The second pulse places an 8-bit vector on the data bus. The vector combines a programmed base with the number of the winning input.

Software sets the controller up through a small register window: chip select, read and write strobes, one address bit and an 8-bit data bus. The data bus is split into an input, an output and an output enable, to be joined at a pad. A start word resets the setup sequence. It is followed by the vector base, an optional cascade word and an optional option word. After that, writes load the mask, issue end-of-interrupt commands or choose which status register a read returns. The cascade word is taken in and then discarded. The CPU-mode option bit is taken in but changes nothing.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the controller is not operational: `int_o` and `data_oe` are low, and `int_o` stays low even with an input high, until setup completes.
- R2: A write with `addr`=0 and data bit 4 set starts setup. It clears the mask and the in-service register. It latches three fields: bit 3 chooses level (1) or edge (0) inputs, bit 1 chooses single controller (1) or cascade (0), and bit 0 asks for the option word (1).
- R3: The setup words after the start word are written at `addr`=1, in this order: the base word, then the cascade word only when bit 1 of the start word was 0, then the option word only when bit 0 of the start word was 1. After the last word the controller is operational. From then on, writes at `addr`=1 load the mask, and no setup write touches the mask.
- R4: The vector is base-word bits 7..3 in bits 7..3, with the 3-bit input number in bits 2..0. For example, a base of 0x40 and input 6 give 0x46.
- R5: Mask bit k set to 1 blocks input k from raising `int_o`. A read at `addr`=1 returns the mask.
- R6: Priority is fixed, with input 0 highest. `int_o` is high exactly when the controller is operational and some unmasked request has a higher priority than every in-service bit.
- R7: On the first acknowledge pulse, the in-service bit of the winning input is set. In edge mode that input's request bit is also cleared. During the second pulse, `data_oe` is high and `data_o` carries the vector.
- R8: When option-word bit 1 is set (auto end-of-interrupt), the in-service bit set by an acknowledge is cleared when the second pulse ends.
- R9: A write of 0x20 at `addr`=0 while operational clears the highest-priority set in-service bit.
- R10: A write at `addr`=0 with bits 4..3 equal to 01 and bit 1 set selects the status returned by reads at `addr`=0: bit 0 = 1 selects the in-service register and bit 0 = 0 selects the request register. Every start word selects the request register.
- R11: In edge mode a request bit is set only by a 0-to-1 change of its input. An input held high after its acknowledge does not request again.
- R12: In level mode each request bit follows its input: it is 1 while the input is high and 0 once the input is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Register window select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; one write per falling edge |
| addr | input | 1 | Register window address bit |
| data_i | input | 8 | Write data from the CPU |
| data_o | output | 8 | Read data or vector towards the CPU |
| data_oe | output | 1 | Enable for driving `data_o` onto the shared bus |
| irq_i | input | 8 | Interrupt request inputs, bit 0 highest priority |
| int_o | output | 1 | Interrupt request to the CPU |
| ack_n | input | 1 | Interrupt acknowledge from the CPU, active low |

## Verification
The hardest state to reach is nested service. In that state a lower-priority input is in service, another request is pending below it, and a higher-priority input then arrives. The interrupt line must be low, then high, and each end-of-interrupt must remove only the topmost in-service bit. The stimulus builds this state with full acknowledge sequences and does not force internal state. The in-service and request registers are read through the status-select word after every step. The conditional skipping of the setup words is shown only by where the next `addr`=1 write lands. So each start-word variant is followed by a mask write and a mask read-back, and the mask is also read in the middle of the sequence.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // Setup sequencer position
   typedef enum logic [2:0] {
      SEQ_OFF,
      SEQ_BASE,
      SEQ_LINK,
      SEQ_OPT,
      SEQ_RUN
   } seq_t;

   // Acknowledge handshake position
   typedef enum logic [1:0] {
      ACK_IDLE,
      ACK_HELD,
      ACK_VEC
   } ackph_t;

   // Latched configuration flags
   typedef struct packed {
      logic level;
      logic single;
      logic need_opt;
      logic auto_eoi;
      logic rd_isr;
   } cfg_t;
endpackage

// File: rtl/irqc_regif.sv
module irqc_regif
   import irqc_pkg::*;
#(
   parameter int DW    = 8,
   parameter int IDX_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_stb,
   input  logic                addr,
   input  logic [DW-1:0]       wdata,
   output cfg_t                cfg_o,
   output logic [DW-IDX_W-1:0] base_o,
   output logic [DW-1:0]       imr_o,
   output logic                running_o,
   output logic                init_clr_o,
   output logic                eoi_ns_o
);
   localparam int             BASE_W  = DW - IDX_W;
   localparam logic [DW-1:0]  EOI_CMD = DW'(8'h20);

   seq_t              seq_q;
   cfg_t              cfg_q;
   logic [BASE_W-1:0] base_q;
   logic [DW-1:0]     imr_q;
   logic              start_w;

   assign start_w    = wr_stb && !addr && wdata[4];
   assign init_clr_o = start_w;
   assign eoi_ns_o   = wr_stb && !addr && (seq_q == SEQ_RUN) && (wdata == EOI_CMD);
   assign running_o  = (seq_q == SEQ_RUN);
   assign cfg_o      = cfg_q;
   assign base_o     = base_q;
   assign imr_o      = imr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q  <= SEQ_OFF;
         cfg_q  <= '0;
         base_q <= '0;
         imr_q  <= '0;
      end else if (start_w) begin
         seq_q          <= SEQ_BASE;
         cfg_q.level    <= wdata[3];
         cfg_q.single   <= wdata[1];
         cfg_q.need_opt <= wdata[0];
         cfg_q.auto_eoi <= 1'b0;
         cfg_q.rd_isr   <= 1'b0;
         imr_q          <= '0;
      end else if (wr_stb) begin
         unique case (seq_q)
            SEQ_BASE: if (addr) begin
               base_q <= wdata[DW-1:IDX_W];
               if (!cfg_q.single)       seq_q <= SEQ_LINK;
               else if (cfg_q.need_opt) seq_q <= SEQ_OPT;
               else                     seq_q <= SEQ_RUN;
            end
            SEQ_LINK: if (addr) begin
               seq_q <= cfg_q.need_opt ? SEQ_OPT : SEQ_RUN;
            end
            SEQ_OPT: if (addr) begin
               cfg_q.auto_eoi <= wdata[1];
               seq_q          <= SEQ_RUN;
            end
            SEQ_RUN: begin
               if (addr)                           imr_q        <= wdata;
               else if (wdata[3] && wdata[1])      cfg_q.rd_isr <= wdata[0];
            end
            default: ;
         endcase
      end
   end

   // R2
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_w |=> (imr_q == '0) && (seq_q == SEQ_BASE) && !cfg_q.rd_isr);

   // R3
   mask_only_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !start_w && (seq_q != SEQ_RUN)) |=> $stable(imr_q));
endmodule

// File: rtl/irqc_capture.sv
module irqc_capture #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_i,
   input  logic         level_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] irr_o
);
   logic [N-1:0] irq_q;
   logic [N-1:0] irr_q;

   for (genvar g = 0; g < N; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_q[g] <= 1'b0;
            irr_q[g] <= 1'b0;
         end else begin
            irq_q[g] <= irq_i[g];
            if (level_i) irr_q[g] <= irq_i[g];
            else         irr_q[g] <= (irr_q[g] && !clr_i[g]) || (irq_i[g] && !irq_q[g]);
         end
      end
   end

   assign irr_o = irr_q;

   // R11
   edge_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_i && ((irq_i & ~irq_q) == '0)) |=> ((irr_q & ~$past(irr_q)) == '0));

   // R12
   level_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level_i |=> (irr_q == $past(irq_i)));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
   import irqc_pkg::*;
#(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     irr_i,
   input  logic [N-1:0]     imr_i,
   input  logic             running_i,
   input  logic             level_i,
   input  logic             auto_eoi_i,
   input  logic             init_clr_i,
   input  logic             eoi_ns_i,
   input  logic             ack_n,
   output logic             int_o,
   output logic [N-1:0]     isr_o,
   output logic [N-1:0]     ack_clr_o,
   output logic             vec_en_o,
   output logic [IDX_W-1:0] win_idx_o
);
   ackph_t           ph_q;
   logic             ack_q;
   logic [N-1:0]     isr_q, held_oh_q, isr_nxt;
   logic [IDX_W-1:0] held_idx_q, win_idx;
   logic [N-1:0]     pend, isr_low, allowed, elig, win_oh;
   logic             ack_fall, ack_rise, ack_first, vec_end;

   assign pend    = irr_i & ~imr_i;
   assign isr_low = isr_q & (~isr_q + 1'b1);
   assign allowed = (isr_q == '0) ? '1 : (isr_low - 1'b1);
   assign elig    = pend & allowed;
   assign win_oh  = elig & (~elig + 1'b1);

   always_comb begin
      win_idx = IDX_W'(N - 1);
      for (int k = N - 1; k >= 0; k--) begin
         if (elig[k]) win_idx = IDX_W'(k);
      end
   end

   assign ack_fall  = ack_q && !ack_n;
   assign ack_rise  = !ack_q && ack_n;
   assign ack_first = ack_fall && (ph_q == ACK_IDLE);
   assign vec_end   = ack_rise && (ph_q == ACK_VEC);

   always_comb begin
      isr_nxt = isr_q;
      if (ack_first)              isr_nxt = isr_nxt | win_oh;
      if (vec_end && auto_eoi_i)  isr_nxt = isr_nxt & ~held_oh_q;
      if (eoi_ns_i)               isr_nxt = isr_nxt & ~isr_low;
      if (init_clr_i)             isr_nxt = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q       <= ACK_IDLE;
         ack_q      <= 1'b1;
         isr_q      <= '0;
         held_oh_q  <= '0;
         held_idx_q <= '0;
      end else begin
         ack_q <= ack_n;
         isr_q <= isr_nxt;
         unique case (ph_q)
            ACK_IDLE: if (ack_fall) begin
               ph_q       <= ACK_HELD;
               held_oh_q  <= win_oh;
               held_idx_q <= win_idx;
            end
            ACK_HELD: if (ack_fall) ph_q <= ACK_VEC;
            ACK_VEC:  if (ack_rise) ph_q <= ACK_IDLE;
            default:  ph_q <= ACK_IDLE;
         endcase
      end
   end

   assign int_o     = running_i && (elig != '0);
   assign isr_o     = isr_q;
   assign ack_clr_o = (ack_first && !level_i) ? win_oh : '0;
   assign vec_en_o  = (ph_q == ACK_VEC) && !ack_n;
   assign win_idx_o = held_idx_q;

   // R7
   first_pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_first && (elig != '0) && !init_clr_i) |=> ((isr_q & held_oh_q) != '0));

   // R8
   auto_eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_end && auto_eoi_i) |=> ((isr_q & $past(held_oh_q)) == '0));

   // R9
   eoi_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_ns_i && (isr_q != '0) && !ack_first) |=> ($countones(isr_q) < $past($countones(isr_q))));
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
   import irqc_pkg::*;
#(
   parameter int N_IN = 8,
   parameter int DW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n,
   input  logic            rd_n,
   input  logic            wr_n,
   input  logic            addr,
   input  logic [DW-1:0]   data_i,
   output logic [DW-1:0]   data_o,
   output logic            data_oe,
   input  logic [N_IN-1:0] irq_i,
   output logic            int_o,
   input  logic            ack_n
);
   localparam int IDX_W  = $clog2(N_IN);
   localparam int BASE_W = DW - IDX_W;

   if (N_IN != DW) begin : g_bad_width
      $error("irq_ctrl8: N_IN must equal DW");
   end
   if ((1 << IDX_W) != N_IN || N_IN < 8) begin : g_bad_count
      $error("irq_ctrl8: N_IN must be a power of two of at least 8");
   end

   logic              wr_q, wr_stb;
   cfg_t              cfg;
   logic [BASE_W-1:0] base;
   logic [DW-1:0]     imr;
   logic              running, init_clr, eoi_ns, vec_en;
   logic [N_IN-1:0]   irr, isr, ack_clr;
   logic [IDX_W-1:0]  win_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_q <= 1'b1;
      else        wr_q <= wr_n || cs_n;
   end
   assign wr_stb = !cs_n && !wr_n && wr_q;

   irqc_regif #(.DW(DW), .IDX_W(IDX_W)) u_regif (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr), .wdata(data_i),
      .cfg_o(cfg), .base_o(base), .imr_o(imr), .running_o(running),
      .init_clr_o(init_clr), .eoi_ns_o(eoi_ns)
   );

   irqc_capture #(.N(N_IN)) u_capture (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .level_i(cfg.level),
      .clr_i(ack_clr), .irr_o(irr)
   );

   irqc_arbiter #(.N(N_IN), .IDX_W(IDX_W)) u_arbiter (
      .clk(clk), .rst_n(rst_n), .irr_i(irr), .imr_i(imr), .running_i(running),
      .level_i(cfg.level), .auto_eoi_i(cfg.auto_eoi), .init_clr_i(init_clr),
      .eoi_ns_i(eoi_ns), .ack_n(ack_n), .int_o(int_o), .isr_o(isr),
      .ack_clr_o(ack_clr), .vec_en_o(vec_en), .win_idx_o(win_idx)
   );

   always_comb begin
      if (vec_en)         data_o = {base, win_idx};
      else if (addr)      data_o = imr;
      else if (cfg.rd_isr) data_o = isr;
      else                data_o = irr;
   end
   assign data_oe = vec_en || (!cs_n && !rd_n);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !int_o);
endmodule

// File: tb/tb_irq_ctrl8.sv
module tb_irq_ctrl8;
   localparam int CLK_P = 10;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0, ack_n = 1'b1;
   logic [7:0] data_i = '0, irq = '0;
   logic [7:0] data_o;
   logic       data_oe, int_o;
   int         n_chk = 0, n_bad = 0;

   irq_ctrl8 dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .data_i(data_i), .data_o(data_o), .data_oe(data_oe), .irq_i(irq),
      .int_o(int_o), .ack_n(ack_n)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk); cs_n = 0; wr_n = 0; addr = a; data_i = d;
      @(negedge clk); cs_n = 1; wr_n = 1;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
      #1 d = data_o;
      @(negedge clk); cs_n = 1; rd_n = 1;
   endtask

   task automatic ack(output logic [7:0] vec, output logic oe);
      @(negedge clk); ack_n = 0;
      @(negedge clk); ack_n = 1;
      @(negedge clk); ack_n = 0;
      @(negedge clk); vec = data_o; oe = data_oe; ack_n = 1;
      @(negedge clk);
   endtask

   task automatic set_irq(input logic [7:0] v);
      @(negedge clk); irq = v;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 int after reset", {7'b0, int_o}, 8'h00);
      chk("R1 oe after reset", {7'b0, data_oe}, 8'h00);
      set_irq(8'h04);
      chk("R1 int while unconfigured", {7'b0, int_o}, 8'h00);
      set_irq(8'h00);
   endtask

   task automatic t_edge_nest();
      logic [7:0] d, v; logic oe;
      wr(0, 8'h13); wr(1, 8'h08); wr(1, 8'h01);
      rd(1, d); chk("R2 mask cleared by start", d, 8'h00);
      wr(1, 8'hFF); rd(1, d); chk("R3 R5 mask write after setup", d, 8'hFF);
      wr(1, 8'h00);
      set_irq(8'h24);
      chk("R6 int with pending", {7'b0, int_o}, 8'h01);
      ack(v, oe);
      chk("R4 R7 vector input 2", v, 8'h0A);
      chk("R7 data_oe in second pulse", {7'b0, oe}, 8'h01);
      wr(0, 8'h0A); rd(0, d); chk("R7 R10 R11 irr after ack", d, 8'h20);
      wr(0, 8'h0B); rd(0, d); chk("R10 isr after ack", d, 8'h04);
      chk("R6 lower request blocked", {7'b0, int_o}, 8'h00);
      wr(0, 8'h20); rd(0, d); chk("R9 eoi clears", d, 8'h00);
      chk("R6 pending 5 now raises", {7'b0, int_o}, 8'h01);
      ack(v, oe); chk("R4 vector input 5", v, 8'h0D);
      set_irq(8'h26);
      chk("R6 higher nests", {7'b0, int_o}, 8'h01);
      ack(v, oe); chk("R4 vector input 1", v, 8'h09);
      rd(0, d); chk("R7 nested isr", d, 8'h22);
      wr(0, 8'h20); rd(0, d); chk("R9 eoi clears top only", d, 8'h20);
      wr(0, 8'h20); rd(0, d); chk("R9 second eoi", d, 8'h00);
      set_irq(8'h00);
   endtask

   task automatic t_mask();
      logic [7:0] d, v; logic oe;
      wr(1, 8'h08); set_irq(8'h08);
      chk("R5 masked input quiet", {7'b0, int_o}, 8'h00);
      wr(0, 8'h0A); rd(0, d); chk("R10 masked request visible", d, 8'h08);
      wr(1, 8'h00);
      chk("R5 unmask raises", {7'b0, int_o}, 8'h01);
      ack(v, oe); chk("R4 vector input 3", v, 8'h0B);
      wr(0, 8'h20); set_irq(8'h00);
   endtask

   task automatic t_auto();
      logic [7:0] d, v; logic oe;
      wr(1, 8'h08);
      wr(0, 8'h13); wr(1, 8'h40); wr(1, 8'h03);
      rd(1, d); chk("R2 restart clears mask", d, 8'h00);
      set_irq(8'h40);
      ack(v, oe); chk("R4 vector base 40", v, 8'h46);
      wr(0, 8'h0B); rd(0, d); chk("R8 auto eoi clears isr", d, 8'h00);
      set_irq(8'h00);
   endtask

   task automatic t_level();
      logic [7:0] d;
      wr(0, 8'h1A); wr(1, 8'h20);
      wr(1, 8'h5A); rd(1, d); chk("R3 no option word skipped", d, 8'h5A);
      wr(1, 8'h00);
      set_irq(8'h80);
      wr(0, 8'h0A); rd(0, d); chk("R12 level follows high", d, 8'h80);
      chk("R6 level int", {7'b0, int_o}, 8'h01);
      set_irq(8'h00); rd(0, d); chk("R12 level follows low", d, 8'h00);
      chk("R12 int drops", {7'b0, int_o}, 8'h00);
   endtask

   task automatic t_cascade();
      logic [7:0] d;
      wr(0, 8'h11); wr(1, 8'h10);
      rd(1, d); chk("R3 mask untouched mid setup", d, 8'h00);
      wr(1, 8'h04); wr(1, 8'h01);
      wr(1, 8'h33); rd(1, d); chk("R3 cascade with option", d, 8'h33);
      wr(0, 8'h10); wr(1, 8'h10); wr(1, 8'h00);
      wr(1, 8'hC3); rd(1, d); chk("R3 cascade without option", d, 8'hC3);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_edge_nest();
      t_mask();
      t_auto();
      t_level();
      t_cascade();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule